// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that controls a bank of quasi-bidirectional I/O pins. The bank is 8 or 16 pins wide, chosen by a parameter. There is no command byte and no register pointer. A write transfer loads data bytes straight into an output latch. A read transfer returns the levels that are present on the pins. Each pin is modelled as a strong low driver plus an external weak pull-up. A latch bit of 1 releases the pin, so the pin reads high or serves as an input. A latch bit of 0 drives the pin low.

The target address has seven bits. Three select inputs supply the low bits. A parameter picks the upper bits: 0x20–0x27 for the base variant or 0x38–0x3F for the alternate variant. An active-low interrupt output reports that the pins now differ from the snapshot taken at the last read. The interrupt clears when the port is read, or when the pins return to that snapshot. SCL and SDA pass through two-flop synchronisers into the system clock domain.

There is no data stream at the block's edge, so there is no valid/ready interface. All pins are plain control and status signals.

Top module: `qb_expander`

## Requirements
- R1: After reset the latch holds all ones: `pin_out` is all ones, `pin_oe` is all zeros, `irq_n` is 1 and `sda_oe` is 0.
- R2: The target acknowledges an address byte whose upper seven bits equal {prefix, `addr_sel`}, with prefix 4'b0100 when ALT_ADDR=0 and 4'b0111 when ALT_ADDR=1. Any other address is not acknowledged, and the latch is left unchanged.
- R3: On a write (address LSB 0), each received data byte is acknowledged and written into the latch at its acknowledge clock. The latch keeps its value at all other times.
- R4: For each pin, `pin_out` equals its latch bit and `pin_oe` is the inverse of that bit. A 1 releases the pin and a 0 drives it low.
- R5: On a read (address LSB 1), the target returns the synchronised `pin_in` levels MSB first, not the latch. A pin driven low by the latch therefore reads 0.
- R6: With PINS=16, the first data byte of a transfer covers pins 7..0 and the second byte covers pins 15..8, for both writes and reads. With PINS=8, every byte covers all pins.
- R7: With PINS=16, further bytes in the same transfer keep alternating between the low half and the high half.
- R8: `irq_n` goes low three clock cycles after a `pin_in` change makes the pins differ from the snapshot. The snapshot resets to all ones.
- R9: Reading a byte updates the matching half of the snapshot. Once the snapshot matches the pins, `irq_n` returns high.
- R10: If the pins return to the snapshot without a read, `irq_n` returns high three cycles later.
- R11: When the host NACKs a read byte, the target releases SDA and goes idle. A STOP releases SDA on the next cycle. A START or repeated START restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | When high, the target pulls SDA low |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_in | input | PINS | Present level of each pin |
| pin_out | output | PINS | Latch value per pin |
| pin_oe | output | PINS | Strong low driver enable per pin |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
Latch updates reach `pin_out` and `pin_oe` on the cycle after the acknowledge-clock edge, which the synchroniser sees about three cycles after the SCL fall. The interrupt trails a pin change by exactly three cycles: two synchroniser stages plus the flag register. The bench's reference model keeps a three-deep history of the applied pin values and compares `irq_n` and `pin_oe` on every falling edge, outside bus transfers. During a transfer the model's expected latch and snapshot are held back. They are updated only after the STOP has settled, and the every-clock comparison resumes six cycles later. Read data and acknowledges are sampled by the bench's bus master in the middle of the SCL high phase. This is well after the target's SDA update, which occurs a few cycles after each SCL fall.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } qbx_state_e;
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qbx_i2c_target.sv
module qbx_i2c_target
  import qbx_pkg::*;
#(
  parameter bit TWO_BYTE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [6:0] addr_i,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic       rd_stb,
  output logic       byte_hi,
  output logic [7:0] wr_byte
);
  qbx_state_e state;
  logic       scl_q, sda_q;
  logic [7:0] shreg;
  logic [2:0] bitcnt;
  logic       got8, rnw, nack;

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  // Data strobes to the port bank: a write byte lands at the acknowledge
  // clock, and a read byte is fetched just before its first bit is driven.
  assign wr_stb  = (state == ST_WDATA) & got8 & scl_fall & ~start_c & ~stop_c;
  assign rd_stb  = scl_fall & ~start_c & ~stop_c &
                   (((state == ST_AACK) & rnw) | ((state == ST_RACK) & ~nack));
  assign wr_byte = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      got8    <= 1'b0;
      rnw     <= 1'b0;
      nack    <= 1'b0;
      byte_hi <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_c) begin
      state   <= ST_ADDR;
      bitcnt  <= '0;
      got8    <= 1'b0;
      byte_hi <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) got8 <= 1'b1;
          end else if (scl_fall && got8) begin
            got8 <= 1'b0;
            if (state == ST_WDATA) begin
              sda_oe <= 1'b1;
              state  <= ST_WACK;
            end else if (shreg[7:1] == addr_i) begin
              sda_oe <= 1'b1;
              rnw    <= shreg[0];
              state  <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rnw) begin
              shreg  <= {rd_byte[6:0], 1'b0};
              sda_oe <= ~rd_byte[7];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            byte_hi <= TWO_BYTE ? ~byte_hi : 1'b0;
            state   <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              sda_oe  <= 1'b0;
              byte_hi <= TWO_BYTE ? ~byte_hi : 1'b0;
              state   <= ST_RACK;
            end else begin
              sda_oe <= ~shreg[7];
              shreg  <= {shreg[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (nack) begin
              state <= ST_IDLE;
            end else begin
              shreg  <= {rd_byte[6:0], 1'b0};
              sda_oe <= ~rd_byte[7];
              state  <= ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qbx_port.sv
module qbx_port #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_s,
  input  logic            wr_stb,
  input  logic            rd_stb,
  input  logic            byte_hi,
  input  logic [7:0]      wr_byte,
  output logic [7:0]      rd_byte,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq_n
);
  localparam int NB = PINS / 8;

  logic [PINS-1:0] latch;
  logic [PINS-1:0] snap;
  logic [NB-1:0]   hit;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign hit[g] = (NB == 1) || (byte_hi == g[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch[g*8 +: 8] <= 8'hFF;
        snap[g*8 +: 8]  <= 8'hFF;
      end else begin
        if (wr_stb && hit[g]) latch[g*8 +: 8] <= wr_byte;
        if (rd_stb && hit[g]) snap[g*8 +: 8]  <= pin_s[g*8 +: 8];
      end
    end
  end

  always_comb begin
    rd_byte = pin_s[7:0];
    for (int b = 0; b < NB; b++) begin
      if (hit[b]) rd_byte = pin_s[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~|(pin_s ^ snap);
  end

  assign pin_out = latch;
  assign pin_oe  = ~latch;
endmodule

// File: rtl/qb_expander.sv
module qb_expander #(
  parameter int PINS     = 16,
  parameter bit ALT_ADDR = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic [2:0]      addr_sel,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq_n
);
  localparam logic [3:0] ADDR_HI  = ALT_ADDR ? 4'b0111 : 4'b0100;
  localparam bit         TWO_BYTE = (PINS == 16);

  logic [1:0]      bus_s;
  logic            scl_s, sda_s;
  logic [PINS-1:0] pin_s;
  logic            wr_stb, rd_stb, byte_hi;
  logic [7:0]      wr_byte, rd_byte;

  qbx_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  qbx_sync #(.W(PINS), .RST_VAL({PINS{1'b1}})) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  qbx_i2c_target #(.TWO_BYTE(TWO_BYTE)) u_target (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .addr_i({ADDR_HI, addr_sel}), .rd_byte(rd_byte), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .byte_hi(byte_hi), .wr_byte(wr_byte)
  );

  qbx_port #(.PINS(PINS)) u_port (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .byte_hi(byte_hi), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n)
  );
endmodule

// File: rtl/qb_expander_chk.sv
module qb_expander_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] pin_out,
  input logic            wr_stb,
  input logic            rd_stb,
  input logic            byte_hi,
  input logic            scl_s,
  input logic            sda_s,
  input logic            sda_oe
);
  // R3: the latch only moves on a write strobe
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(pin_out));

  // R2: the target only starts pulling SDA while SCL is low
  assert_sda_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R11: a STOP releases SDA on the next cycle
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_s) && scl_s && $past(scl_s)) |=> !sda_oe);

  // R5: read fetch and write capture never coincide
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));

  if (PINS == 16) begin : g_wide
    // R6: a low-half byte leaves pins 15..8 alone
    assert_half_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !byte_hi) |=> $stable(pin_out[PINS-1:8]));
  end else begin : g_narrow
    // R6: the narrow bank never selects a high half
    assert_single_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !byte_hi);
  end
endmodule

bind qb_expander qb_expander_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .byte_hi(byte_hi), .scl_s(scl_s), .sda_s(sda_s),
  .sda_oe(sda_oe)
);

// File: tb/qb_expander_test.sv
`timescale 1ns/1ps
module qb_expander_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [15:0] ext16 = 16'hFFFF;
  logic [7:0]  ext8  = 8'hFF;
  wire sda_oe16, sda_oe8, irq16, irq8;
  wire [15:0] p_out16, p_oe16, p_in16;
  wire [7:0]  p_out8, p_oe8, p_in8;
  wire sda_line = m_sda & ~sda_oe16 & ~sda_oe8;
  assign p_in16 = ext16 & ~p_oe16;
  assign p_in8  = ext8 & ~p_oe8;

  qb_expander #(.PINS(16), .ALT_ADDR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe16), .addr_sel(3'b101), .pin_in(p_in16),
    .pin_out(p_out16), .pin_oe(p_oe16), .irq_n(irq16));

  qb_expander #(.PINS(8), .ALT_ADDR(1'b1)) uut8 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe8), .addr_sel(3'b010), .pin_in(p_in8),
    .pin_out(p_out8), .pin_oe(p_oe8), .irq_n(irq8));

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;
  logic [15:0] exp_lat16 = 16'hFFFF, exp_snap16 = 16'hFFFF;
  logic [7:0]  exp_lat8 = 8'hFF, exp_snap8 = 8'hFF;
  logic [15:0] h16 [3];
  logic [7:0]  h8 [3];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural delay line of applied pin values
  always @(posedge clk) begin
    h16[2] <= h16[1]; h16[1] <= h16[0]; h16[0] <= p_in16;
    h8[2]  <= h8[1];  h8[1]  <= h8[0];  h8[0]  <= p_in8;
  end

  // every-clock comparison against the reference model (R4, R8, R10)
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(p_oe16 === ~exp_lat16, "R4 oe16", {16'h0, p_oe16}, {16'h0, ~exp_lat16});
      chk(p_oe8 === ~exp_lat8, "R4 oe8", {24'h0, p_oe8}, {24'h0, ~exp_lat8});
      chk(irq16 === (h16[2] == exp_snap16), "R8 irq16", {31'h0, irq16},
          {31'h0, h16[2] == exp_snap16});
      chk(irq8 === (h8[2] == exp_snap8), "R8 irq8", {31'h0, irq8},
          {31'h0, h8[2] == exp_snap8});
    end
  end

  task automatic hw(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic i2c_start();
    cmp_en = 1'b0;
    m_sda = 1'b1; hw(HALF);
    m_scl = 1'b1; hw(HALF);
    m_sda = 1'b0; hw(HALF);
    m_scl = 1'b0; hw(HALF);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hw(HALF);
    m_scl = 1'b1; hw(HALF);
    m_sda = 1'b1; hw(HALF);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; hw(HALF);
    m_scl = 1'b1; hw(HALF);
    m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; hw(HALF);
    m_scl = 1'b1; hw(HALF / 2);
    b = sda_line; hw(HALF / 2);
    m_scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    send_bit(last);
  endtask

  task automatic settle();
    hw(6);
    @(negedge clk);
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rd;
    hw(10);
    @(negedge clk);
    // R1 reset state
    chk(p_out16 === 16'hFFFF, "R1 out16", {16'h0, p_out16}, 32'hFFFF);
    chk(p_oe16 === 16'h0, "R1 oe16", {16'h0, p_oe16}, 32'h0);
    chk(p_out8 === 8'hFF, "R1 out8", {24'h0, p_out8}, 32'hFF);
    chk(irq16 === 1'b1 && irq8 === 1'b1, "R1 irq", {30'h0, irq16, irq8}, 32'h3);
    chk(sda_oe16 === 1'b0 && sda_oe8 === 1'b0, "R1 sda", {30'h0, sda_oe16, sda_oe8}, 32'h0);
    rst_n = 1'b1;
    hw(4);
    settle();

    // R2 R3 R6: two-byte write to 0x25, low half first
    i2c_start();
    wbyte({7'h25, 1'b0}, ack); chk(ack, "R2 addr ack", {31'h0, ack}, 32'h1);
    wbyte(8'h5A, ack); chk(ack, "R3 data ack", {31'h0, ack}, 32'h1);
    wbyte(8'hC3, ack); chk(ack, "R3 data ack2", {31'h0, ack}, 32'h1);
    i2c_stop();
    exp_lat16 = 16'hC35A;
    chk(p_out16 === 16'hC35A, "R6 write order", {16'h0, p_out16}, 32'hC35A);
    settle();
    hw(2);
    chk(irq16 === 1'b0, "R8 irq after drive", {31'h0, irq16}, 32'h0);

    // R5 R9: read returns pin levels, not latch
    @(negedge clk); ext16 = 16'hFFF0;
    hw(4);
    i2c_start();
    wbyte({7'h25, 1'b1}, ack); chk(ack, "R2 read addr ack", {31'h0, ack}, 32'h1);
    rbyte(rd, 1'b0); chk(rd === 8'h50, "R5 read low", {24'h0, rd}, 32'h50);
    rbyte(rd, 1'b1); chk(rd === 8'hC3, "R6 read high", {24'h0, rd}, 32'hC3);
    i2c_stop();
    exp_snap16 = 16'hC350;
    settle();
    hw(2);
    chk(irq16 === 1'b1, "R9 irq cleared by read", {31'h0, irq16}, 32'h1);

    // R8 R10: input change and return
    @(negedge clk); ext16[15] = 1'b0;
    hw(2); @(negedge clk);
    chk(irq16 === 1'b1, "R8 not yet", {31'h0, irq16}, 32'h1);
    hw(3); @(negedge clk);
    chk(irq16 === 1'b0, "R8 asserted", {31'h0, irq16}, 32'h0);
    ext16[15] = 1'b1;
    hw(5); @(negedge clk);
    chk(irq16 === 1'b1, "R10 returned", {31'h0, irq16}, 32'h1);

    // R2 address mismatch
    i2c_start();
    wbyte({7'h24, 1'b0}, ack); chk(!ack, "R2 mismatch nack", {31'h0, ack}, 32'h0);
    wbyte(8'h00, ack);
    i2c_stop();
    chk(p_out16 === 16'hC35A, "R2 latch kept", {16'h0, p_out16}, 32'hC35A);
    chk(p_out8 === 8'hFF, "R2 other kept", {24'h0, p_out8}, 32'hFF);
    settle();

    // R7: third byte wraps to low half
    i2c_start();
    wbyte({7'h25, 1'b0}, ack);
    wbyte(8'h11, ack); wbyte(8'h22, ack); wbyte(8'h33, ack);
    i2c_stop();
    exp_lat16 = 16'h2233;
    chk(p_out16 === 16'h2233, "R7 alternate", {16'h0, p_out16}, 32'h2233);
    settle();

    // R2 alternate prefix and R6 narrow bank: every byte covers all pins
    i2c_start();
    wbyte({7'h3A, 1'b0}, ack); chk(ack, "R2 alt addr ack", {31'h0, ack}, 32'h1);
    wbyte(8'hA5, ack); wbyte(8'h0F, ack);
    i2c_stop();
    exp_lat8 = 8'h0F;
    chk(p_out8 === 8'h0F, "R6 narrow latch", {24'h0, p_out8}, 32'h0F);
    settle();
    i2c_start();
    wbyte({7'h3A, 1'b1}, ack);
    rbyte(rd, 1'b1); chk(rd === 8'h0F, "R5 narrow read", {24'h0, rd}, 32'h0F);
    i2c_stop();
    exp_snap8 = 8'h0F;
    settle();

    // R11: host NACK releases SDA, repeated START restarts
    i2c_start();
    wbyte({7'h25, 1'b1}, ack);
    rbyte(rd, 1'b1); chk(rd === 8'h30, "R5 low pins", {24'h0, rd}, 32'h30);
    hw(4);
    chk(sda_oe16 === 1'b0, "R11 released after nack", {31'h0, sda_oe16}, 32'h0);
    i2c_start();
    wbyte({7'h25, 1'b0}, ack); chk(ack, "R11 restart ack", {31'h0, ack}, 32'h1);
    wbyte(8'hFF, ack);
    i2c_stop();
    exp_snap16[7:0] = 8'h30;
    exp_lat16 = 16'h22FF;
    chk(p_out16 === 16'h22FF, "R11 write after restart", {16'h0, p_out16}, 32'h22FF);
    hw(2);
    chk(sda_oe16 === 1'b0, "R11 idle after stop", {31'h0, sda_oe16}, 32'h0);
    settle();
    hw(20);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule